// File: doc/BRIEF.md
# Logic Sample Run-Length Word Packer

This block sits between a 16-channel logic sampling front end and a 32-bit-wide capture memory. It receives one sample per asserted valid strobe. In compressed mode it counts how many times in a row the same sample value arrives. It emits one memory word per run, holding the value in the upper half and the repeat count minus one in the lower half. In raw mode it places each pair of consecutive samples into one word, with the earlier sample in the upper half.

Words leave through a one-entry valid/ready slot toward the memory writer. A flush input closes any open run or half-filled pair when capture ends. A word may be needed while the slot is still full and the memory side is not taking it. In that case the block refuses the sample or flush that caused the word and raises a sticky overflow flag. Data is never overwritten without a trace.

Top module: `run_word_packer`

## Requirements
- R1: After reset, word_valid and overflow are 0 and no run or pair is open, so the first accepted sample starts a new run or pair.
- R2: With comp_en=1, a sample whose value differs from the open run emits the word {run value in [31:16], run length minus one in [15:0]}, and the new sample opens a run of length one.
- R3: With comp_en=1, the sample that brings a run to 65536 repetitions emits {value, 16'hFFFF} in the same cycle and closes the run, so the next sample of the same value opens a new run.
- R4: With comp_en=1, flush emits the open run as in R2 and closes it. A flush with no open run emits nothing.
- R5: With comp_en=0, two consecutive samples produce one word with the earlier sample in [31:16] and the later sample in [15:0].
- R6: With comp_en=0, flush with one unpaired sample emits {sample, 16'h0000}. A flush with no unpaired sample emits nothing.
- R7: While word_valid=1 and word_ready=0, word_valid stays 1 and word_data keeps its value.
- R8: A word that is needed while word_valid=1 and word_ready=0 is not produced. The sample or flush that caused it is discarded, the open run or pair is unchanged, and overflow becomes 1 and stays 1 until reset.
- R9: In a cycle with flush=1, smp_valid is ignored and that cycle's sample is not counted.
- R10: Cycles with smp_valid=0 do not split a run or a pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_en | input | 1 | 1: run-length words, 0: raw sample pairs |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Sample value |
| flush | input | 1 | Close the open run or pair at capture end |
| word_valid | output | 1 | Output word present |
| word_data | output | 32 | Output word |
| word_ready | input | 1 | Memory side accepts the word |
| overflow | output | 1 | Sticky: a word was refused for lack of space |

## Verification
A stale held value or a miscounted run shows up at the ports in the first word after the next value change or flush. The error then appears in that word's upper or lower half, at most one cycle after the sample that should close the run. A wrongly cleared open pair or run instead surfaces as a missing word, or as a shifted pairing in the following raw words. An early or missing saturation word takes a full 65536-sample run to expose. A lost backpressure hold is visible the very next cycle, as word_data changing or word_valid dropping while ready is low.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  localparam int SMP_W  = 16;
  localparam int CNT_W  = SMP_W;
  localparam int WORD_W = SMP_W + CNT_W;

  typedef logic [SMP_W-1:0]  smp_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [WORD_W-1:0] word_t;

  // value in the upper half, repeats minus one in the lower half
  function automatic word_t make_run_word(smp_t value, cnt_t reps_m1);
    return {value, reps_m1};
  endfunction

  // earlier sample high, later sample low
  function automatic word_t make_pair_word(smp_t early, smp_t late);
    return {early, late};
  endfunction

  // true when one more repeat fills the counter
  function automatic logic run_at_limit(cnt_t reps_m1);
    return reps_m1 == ~cnt_t'(1);
  endfunction
endpackage

// File: rtl/rwp_run_tracker.sv
module rwp_run_tracker
  import rwp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp_valid,
  input  smp_t  smp_data,
  input  logic  flush,
  input  logic  slot_free,
  output logic  emit_req,
  output word_t emit_word,
  output logic  blocked
);
  logic have_run, nxt_have;
  smp_t held, nxt_held;
  cnt_t cnt, nxt_cnt;
  logic want, commit;

  always_comb begin
    want      = 1'b0;
    emit_word = '0;
    nxt_have  = have_run;
    nxt_held  = held;
    nxt_cnt   = cnt;
    if (flush) begin
      if (have_run) begin
        want      = 1'b1;
        emit_word = make_run_word(held, cnt);
        nxt_have  = 1'b0;
        nxt_cnt   = '0;
      end
    end else if (smp_valid) begin
      if (!have_run) begin
        nxt_have = 1'b1;
        nxt_held = smp_data;
        nxt_cnt  = '0;
      end else if (smp_data != held) begin
        want      = 1'b1;
        emit_word = make_run_word(held, cnt);
        nxt_held  = smp_data;
        nxt_cnt   = '0;
      end else if (run_at_limit(cnt)) begin
        want      = 1'b1;
        emit_word = make_run_word(held, cnt + cnt_t'(1));
        nxt_have  = 1'b0;
        nxt_cnt   = '0;
      end else begin
        nxt_cnt = cnt + cnt_t'(1);
      end
    end
  end

  assign commit   = !want || slot_free;
  assign emit_req = want && slot_free;
  assign blocked  = want && !slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_run <= 1'b0;
      held     <= '0;
      cnt      <= '0;
    end else if (commit) begin
      have_run <= nxt_have;
      held     <= nxt_held;
      cnt      <= nxt_cnt;
    end
  end

  // R2: words only come out of an open run
  p_emit_open_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    emit_req |-> have_run);
  // R3: a full counter never stays stored, the run closes first
  p_no_stored_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    have_run |-> (cnt != '1));
  // R8: a refused word leaves the run untouched
  p_blocked_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> ($stable(held) && $stable(cnt) && $stable(have_run)));
endmodule

// File: rtl/rwp_pair_packer.sv
module rwp_pair_packer
  import rwp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smp_valid,
  input  smp_t  smp_data,
  input  logic  flush,
  input  logic  slot_free,
  output logic  emit_req,
  output word_t emit_word,
  output logic  blocked
);
  logic have_half, nxt_half;
  smp_t first, nxt_first;
  logic want, commit;

  always_comb begin
    want      = 1'b0;
    emit_word = '0;
    nxt_half  = have_half;
    nxt_first = first;
    if (flush) begin
      if (have_half) begin
        want      = 1'b1;
        emit_word = make_pair_word(first, '0);
        nxt_half  = 1'b0;
      end
    end else if (smp_valid) begin
      if (!have_half) begin
        nxt_half  = 1'b1;
        nxt_first = smp_data;
      end else begin
        want      = 1'b1;
        emit_word = make_pair_word(first, smp_data);
        nxt_half  = 1'b0;
      end
    end
  end

  assign commit   = !want || slot_free;
  assign emit_req = want && slot_free;
  assign blocked  = want && !slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_half <= 1'b0;
      first     <= '0;
    end else if (commit) begin
      have_half <= nxt_half;
      first     <= nxt_first;
    end
  end

  // R5: a pair word needs a stored first half
  p_pair_needs_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emit_req |-> have_half);
  // R6: after a flush no half stays open unless it was refused
  p_flush_clears_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !blocked) |=> !have_half);
endmodule

// File: rtl/rwp_out_slot.sv
module rwp_out_slot
  import rwp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_word,
  input  logic  ready,
  output logic  slot_free,
  output logic  valid,
  output word_t data
);
  assign slot_free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_word;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R7: a waiting word is held unchanged
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));
  // R8: producers never load into a busy slot
  p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid || ready));
endmodule

// File: rtl/run_word_packer.sv
module run_word_packer
  import rwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              comp_en,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              flush,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  input  logic              word_ready,
  output logic              overflow
);
  logic  slot_free;
  logic  run_emit, run_blk, pair_emit, pair_blk;
  word_t run_word, pair_word;
  logic  load_any, blocked_any;
  word_t load_word;

  rwp_run_tracker u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid && comp_en),
    .smp_data  (smp_data),
    .flush     (flush && comp_en),
    .slot_free (slot_free),
    .emit_req  (run_emit),
    .emit_word (run_word),
    .blocked   (run_blk)
  );

  rwp_pair_packer u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid && !comp_en),
    .smp_data  (smp_data),
    .flush     (flush && !comp_en),
    .slot_free (slot_free),
    .emit_req  (pair_emit),
    .emit_word (pair_word),
    .blocked   (pair_blk)
  );

  assign load_any    = run_emit || pair_emit;
  assign load_word   = run_emit ? run_word : pair_word;
  assign blocked_any = run_blk || pair_blk;

  rwp_out_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_any),
    .load_word (load_word),
    .ready     (word_ready),
    .slot_free (slot_free),
    .valid     (word_valid),
    .data      (word_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else if (blocked_any) overflow <= 1'b1;
  end

  // R8: the flag never clears on its own
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R8: the flag rises only after a refused word
  p_overflow_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(blocked_any));
  // R2/R5: only one producer is active at a time
  p_single_producer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_emit && pair_emit));
endmodule

// File: tb/test_run_word_packer.sv
`timescale 1ns/1ps
module test_run_word_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        comp_en = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        flush = 1'b0;
  logic        word_valid;
  logic [31:0] word_data;
  logic        word_ready = 1'b1;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  logic [31:0] got[$];

  // behavioural reference state
  bit          m_valid, m_ovf, m_have, m_half;
  logic [31:0] m_data;
  int          m_val, m_len, m_first;

  always #2 clk = ~clk;

  run_word_packer i_run_word_packer (
    .clk(clk), .rst_n(rst_n), .comp_en(comp_en), .smp_valid(smp_valid),
    .smp_data(smp_data), .flush(flush), .word_valid(word_valid),
    .word_data(word_data), .word_ready(word_ready), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic model_reset();
    m_valid = 0; m_ovf = 0; m_have = 0; m_half = 0;
    m_data = '0; m_val = 0; m_len = 0; m_first = 0;
  endtask

  task automatic model_step(input bit v, input int s, input bit f, input bit r);
    bit want = 0;
    logic [31:0] w = '0;
    bit nh = m_have, nf = m_half;
    int nv = m_val, nl = m_len, nfi = m_first;
    bit room = !m_valid || r;
    if (comp_en) begin
      if (f) begin
        if (m_have) begin want = 1; w = {m_val[15:0], 16'(m_len - 1)}; nh = 0; end
      end else if (v) begin
        if (!m_have) begin nh = 1; nv = s; nl = 1; end
        else if (s != m_val) begin want = 1; w = {m_val[15:0], 16'(m_len - 1)}; nv = s; nl = 1; end
        else if (m_len + 1 == 65536) begin want = 1; w = {m_val[15:0], 16'hFFFF}; nh = 0; end
        else nl = m_len + 1;
      end
    end else begin
      if (f) begin
        if (m_half) begin want = 1; w = {m_first[15:0], 16'h0000}; nf = 0; end
      end else if (v) begin
        if (!m_half) begin nf = 1; nfi = s; end
        else begin want = 1; w = {m_first[15:0], s[15:0]}; nf = 0; end
      end
    end
    if (want && !room) m_ovf = 1;
    else begin
      m_have = nh; m_half = nf; m_val = nv; m_len = nl; m_first = nfi;
    end
    if (want && room) begin m_valid = 1; m_data = w; end
    else if (r) m_valid = 0;
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(input bit v, input int s, input bit f, input bit r);
    smp_valid = v; smp_data = 16'(s); flush = f; word_ready = r;
    if (word_valid && r) got.push_back(word_data);
    model_step(v, s, f, r);
    @(posedge clk);
    @(negedge clk);
    chk(word_valid == m_valid, {tag, " word_valid"}, 32'(word_valid), 32'(m_valid));
    if (m_valid) chk(word_data == m_data, {tag, " word_data"}, word_data, m_data);
    chk(overflow == m_ovf, {tag, " overflow"}, 32'(overflow), 32'(m_ovf));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1);
  endtask

  task automatic do_reset();
    rst_n = 0; smp_valid = 0; flush = 0; word_ready = 1;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic chk_got(input string t, input int idx, input logic [31:0] exp);
    chk(got.size() > idx, {t, " word count"}, 32'(got.size()), 32'(idx + 1));
    if (got.size() > idx) chk(got[idx] == exp, {t, " word value"}, got[idx], exp);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(word_valid == 0, "R1 word_valid after reset", 32'(word_valid), 0);
    chk(overflow == 0, "R1 overflow after reset", 32'(overflow), 0);

    // R2 / R4: runs closed by value change and flush
    tag = "R2"; comp_en = 1; got.delete();
    cyc(1, 16'hA0A0, 0, 1); cyc(1, 16'hA0A0, 0, 1); cyc(1, 16'hA0A0, 0, 1);
    cyc(1, 16'h00B1, 0, 1); cyc(1, 16'h00B1, 0, 1); cyc(1, 16'h7C00, 0, 1);
    tag = "R4"; cyc(0, 0, 1, 1); idle(2);
    cyc(0, 0, 1, 1); idle(2); // R4: empty flush emits nothing
    chk_got("R2", 0, 32'hA0A0_0002);
    chk_got("R2", 1, 32'h00B1_0001);
    chk_got("R4", 2, 32'h7C00_0000);
    chk(got.size() == 3, "R4 empty flush", 32'(got.size()), 3);

    // R10: gaps do not split a run
    tag = "R10"; got.delete();
    cyc(1, 16'h1234, 0, 1); idle(3); cyc(1, 16'h1234, 0, 1); idle(1);
    cyc(1, 16'h1234, 0, 1); cyc(0, 0, 1, 1); idle(2);
    chk_got("R10", 0, 32'h1234_0002);

    // R9: sample with flush is ignored
    tag = "R9"; got.delete();
    cyc(1, 16'h0011, 0, 1); cyc(1, 16'h0022, 1, 1); idle(1);
    cyc(0, 0, 1, 1); idle(2);
    chk_got("R9", 0, 32'h0011_0000);
    chk(got.size() == 1, "R9 ignored sample", 32'(got.size()), 1);

    // R3: saturation at 65536 repeats
    tag = "R3"; got.delete();
    for (int i = 0; i < 65536; i++) cyc(1, 16'h0005, 0, 1);
    cyc(1, 16'h0005, 0, 1); cyc(0, 0, 1, 1); idle(2);
    chk_got("R3", 0, 32'h0005_FFFF);
    chk_got("R3", 1, 32'h0005_0000);

    // R5 / R6: raw pairs and odd flush
    tag = "R5"; comp_en = 0; got.delete();
    cyc(1, 16'h0001, 0, 1); cyc(1, 16'h0002, 0, 1); idle(1);
    cyc(1, 16'h0003, 0, 1); cyc(1, 16'h0004, 0, 1);
    tag = "R6"; cyc(1, 16'h0005, 0, 1); cyc(0, 0, 1, 1); idle(2);
    cyc(0, 0, 1, 1); idle(2);
    chk_got("R5", 0, 32'h0001_0002);
    chk_got("R5", 1, 32'h0003_0004);
    chk_got("R6", 2, 32'h0005_0000);
    chk(got.size() == 3, "R6 even flush", 32'(got.size()), 3);

    // R7 / R8: backpressure, refused word, sticky flag
    tag = "R7"; comp_en = 1; got.delete();
    cyc(1, 16'h00AA, 0, 0); cyc(1, 16'h00BB, 0, 0);
    tag = "R8"; cyc(1, 16'h00CC, 0, 0);
    tag = "R7"; cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk(word_valid && word_data == 32'h00AA_0000, "R7 held word", word_data, 32'h00AA_0000);
    tag = "R8"; idle(1); cyc(0, 0, 1, 1); idle(2);
    chk_got("R8", 0, 32'h00AA_0000);
    chk_got("R8", 1, 32'h00BB_0000);
    chk(overflow == 1, "R8 sticky overflow", 32'(overflow), 1);
    do_reset();
    chk(overflow == 0, "R1 overflow cleared by reset", 32'(overflow), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule